// File: doc/BRIEF.md
# Busy-Handshaked ADC Readout Clock Controller

This block sits between an external successive-approximation converter and a host SPI port that runs as a slave. A trigger, typically a periodic timer tick, starts each conversion with its own pulse on the convert output. The block then watches the converter's busy output. Busy must first be seen high, and a later falling edge of busy marks the end of the conversion. Only after that edge does the block generate a burst of serial clocks, one per result bit, so that the converter shifts its word out.

The serial clock is not free-running. It stays low between bursts, and within a burst its period is a fixed number of system clocks that is never below twelve. The same gated clock goes to the host slave port, which can therefore move every word by DMA. The block also shifts the data line into a local register on each rising serial-clock edge. When the burst ends it presents the word with a one-cycle strobe, so words appear in conversion order and none is skipped.

A trigger that arrives while a conversion or readout is in progress is dropped and recorded in a sticky overrun flag. A conversion whose busy edge never comes is abandoned after a timeout and recorded in a sticky timeout flag. One clear input resets both flags.

Top module: `adc_burst_ctrl`

## Requirements
- R1: A trigger sampled while the block is idle raises the convert output for exactly CNV_CYCLES system clocks. Each accepted trigger gives exactly one convert pulse.
- R2: No serial clock edge is generated until the synchronized busy input has been seen high after the convert pulse and has then fallen. A busy fall while idle produces no clock.
- R3: Each burst contains exactly WORD_W rising serial-clock edges (24 by default).
- R4: The serial clock output is low whenever no burst is in progress.
- R5: Within a burst, consecutive rising edges are exactly SCLK_DIV system clocks apart (SCLK_DIV at least 12). Each high phase lasts SCLK_DIV - SCLK_DIV/2 clocks.
- R6: The data input is sampled at each rising serial-clock edge, first bit into the most significant position. After the last falling edge, the strobe pulses high for exactly one cycle while the word output holds the captured word.
- R7: Over a run of many conversions with varying conversion times, the strobed words match the converter's output words in conversion order, with none dropped or repeated.
- R8: A trigger that arrives while the block is not idle starts no convert pulse and sets the sticky overrun flag. The flag stays set until the clear input is pulsed.
- R9: If busy has not fallen within TIMEOUT cycles after the convert pulse ends, the sticky timeout flag is set and the block returns to idle with no clock burst and no strobe. The clear input resets the flag, and the next trigger converts normally.
- R10: After reset, convert, serial clock, strobe and both flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | Sample trigger, one pulse per conversion |
| clr_i | input | 1 | Clears the overrun and timeout flags |
| busy_i | input | 1 | Converter busy output (asynchronous) |
| sdo_i | input | 1 | Converter serial data output |
| cnv_o | output | 1 | Convert pulse to the converter |
| sclk_o | output | 1 | Gated serial clock to the converter and the host slave port |
| word_valid_o | output | 1 | One-cycle strobe when a word is complete |
| word_o | output | WORD_W | Captured result word |
| overrun_o | output | 1 | Sticky flag: trigger dropped while not idle |
| timeout_o | output | 1 | Sticky flag: busy did not fall in time |

## Verification
A behavioural converter model answers each convert pulse. Its busy-high latency varies between conversions, and it shifts out a word whose value the bench computes from the conversion index, with a channel index in the upper nibble that wraps every 16 conversions. Long runs with varying latencies and trigger gaps separate correct ordering and burst gating from off-by-one bit counts, wrong clock period or high-phase width, and swapped bit order. Separate patterns cover a trigger in mid-conversion, a converter that never raises busy, and one whose busy stays high then falls while idle. These isolate the overrun path, the timeout path and the requirement that a busy fall has been armed by a prior high.

// File: rtl/adc_burst_pkg.sv
package adc_burst_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_CONVERT = 3'd1,
    ST_WAIT_HI = 3'd2,
    ST_WAIT_LO = 3'd3,
    ST_SHIFT   = 3'd4,
    ST_DONE    = 3'd5
  } burst_state_t;

endpackage

// File: rtl/adc_rst_sync.sv
module adc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/adc_busy_sync.sv
module adc_busy_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic busy_i,
  output logic busy_s,
  output logic busy_fall
);

  // two synchronizer flops plus one history flop for edge detection
  logic [2:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= 3'b000;
    else        sr_q <= {sr_q[1:0], busy_i};
  end

  assign busy_s    = sr_q[1];
  assign busy_fall = sr_q[2] & ~sr_q[1];

endmodule

// File: rtl/adc_sclk_gen.sv
module adc_sclk_gen #(
  parameter int SCLK_DIV = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic sclk,
  output logic rise,
  output logic fall
);

  localparam int HALF = SCLK_DIV / 2;
  localparam int PW   = $clog2(SCLK_DIV);

  logic [PW-1:0] ph_q, ph_d;
  logic          sclk_q, sclk_d;

  assign rise = en && (ph_q == PW'(HALF - 1));
  assign fall = en && (ph_q == PW'(SCLK_DIV - 1));

  always_comb begin
    ph_d   = ph_q;
    sclk_d = sclk_q;
    if (!en) begin
      ph_d   = '0;
      sclk_d = 1'b0;
    end else begin
      ph_d = fall ? '0 : ph_q + 1'b1;
      if (rise)      sclk_d = 1'b1;
      else if (fall) sclk_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= '0;
      sclk_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      sclk_q <= sclk_d;
    end
  end

  assign sclk = sclk_q;

  // R5: clock may only leave its idle level while enabled
  a_r5_rise_only_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_q) |-> $past(en));

endmodule

// File: rtl/adc_word_capture.sv
module adc_word_capture #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              din,
  output logic [WORD_W-1:0] word
);

  logic [WORD_W-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = sh_q;
    if (shift_en) sh_d = {sh_q[WORD_W-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign word = sh_q;

endmodule

// File: rtl/adc_burst_ctrl.sv
module adc_burst_ctrl
  import adc_burst_pkg::*;
#(
  parameter int WORD_W     = 24,
  parameter int SCLK_DIV   = 12,
  parameter int CNV_CYCLES = 4,
  parameter int TIMEOUT    = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_i,
  input  logic              clr_i,
  input  logic              busy_i,
  input  logic              sdo_i,
  output logic              cnv_o,
  output logic              sclk_o,
  output logic              word_valid_o,
  output logic [WORD_W-1:0] word_o,
  output logic              overrun_o,
  output logic              timeout_o
);

  localparam int CW = $clog2(CNV_CYCLES + 1);
  localparam int TW = $clog2(TIMEOUT + 1);
  localparam int BW = $clog2(WORD_W + 1);

  logic rst_s_n;
  logic busy_s, busy_fall;
  logic sclk_w, sclk_rise, sclk_fall;

  burst_state_t  state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [TW-1:0] tcnt_q, tcnt_d;
  logic [BW-1:0] bit_q, bit_d;
  logic          cnv_q, cnv_d;
  logic          ovr_q, ovr_d;
  logic          tmo_q, tmo_d;
  logic          tmo_set, ovr_set;
  logic          shift_active;

  adc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  adc_busy_sync u_busy (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .busy_i    (busy_i),
    .busy_s    (busy_s),
    .busy_fall (busy_fall)
  );

  assign shift_active = (state_q == ST_SHIFT);

  adc_sclk_gen #(.SCLK_DIV(SCLK_DIV)) u_sclk (
    .clk   (clk),
    .rst_n (rst_s_n),
    .en    (shift_active),
    .sclk  (sclk_w),
    .rise  (sclk_rise),
    .fall  (sclk_fall)
  );

  adc_word_capture #(.WORD_W(WORD_W)) u_cap (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .shift_en (sclk_rise),
    .din      (sdo_i),
    .word     (word_o)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    tcnt_d  = tcnt_q;
    bit_d   = bit_q;
    tmo_set = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        cnt_d = '0;
        if (trig_i) state_d = ST_CONVERT;
      end
      ST_CONVERT: begin
        if (cnt_q == CW'(CNV_CYCLES - 1)) begin
          state_d = ST_WAIT_HI;
          tcnt_d  = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_WAIT_HI: begin
        tcnt_d = tcnt_q + 1'b1;
        if (busy_s) begin
          state_d = ST_WAIT_LO;
        end else if (tcnt_q == TW'(TIMEOUT - 1)) begin
          state_d = ST_IDLE;
          tmo_set = 1'b1;
        end
      end
      ST_WAIT_LO: begin
        tcnt_d = tcnt_q + 1'b1;
        if (busy_fall) begin
          state_d = ST_SHIFT;
          bit_d   = '0;
        end else if (tcnt_q == TW'(TIMEOUT - 1)) begin
          state_d = ST_IDLE;
          tmo_set = 1'b1;
        end
      end
      ST_SHIFT: begin
        if (sclk_fall) begin
          if (bit_q == BW'(WORD_W - 1)) state_d = ST_DONE;
          else                          bit_d   = bit_q + 1'b1;
        end
      end
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  assign ovr_set = trig_i && (state_q != ST_IDLE);
  assign cnv_d   = (state_d == ST_CONVERT);
  assign ovr_d   = ovr_set | (ovr_q & ~clr_i);
  assign tmo_d   = tmo_set | (tmo_q & ~clr_i);

  // register process
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      tcnt_q  <= '0;
      bit_q   <= '0;
      cnv_q   <= 1'b0;
      ovr_q   <= 1'b0;
      tmo_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      tcnt_q  <= tcnt_d;
      bit_q   <= bit_d;
      cnv_q   <= cnv_d;
      ovr_q   <= ovr_d;
      tmo_q   <= tmo_d;
    end
  end

  assign cnv_o        = cnv_q;
  assign sclk_o       = sclk_w;
  assign word_valid_o = (state_q == ST_DONE);
  assign overrun_o    = ovr_q;
  assign timeout_o    = tmo_q;

  a_r1_cnv_needs_trigger: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(cnv_q) |-> ($past(trig_i) && $past(state_q) == ST_IDLE));

  a_r2_shift_needs_fall: assert property (@(posedge clk) disable iff (!rst_s_n)
    (state_q == ST_SHIFT && $past(state_q) == ST_WAIT_LO) |-> $past(busy_fall));

  a_r4_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_s_n)
    (state_q == ST_IDLE) |-> !sclk_w);

  a_r6_valid_single: assert property (@(posedge clk) disable iff (!rst_s_n)
    word_valid_o |=> !word_valid_o);

  a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_s_n)
    (ovr_q && !clr_i) |=> ovr_q);

  a_r9_timeout_sticky: assert property (@(posedge clk) disable iff (!rst_s_n)
    (tmo_q && !clr_i) |=> tmo_q);

endmodule

// File: tb/sim_adc_burst_ctrl.sv
module sim_adc_burst_ctrl;

  localparam int W    = 24;
  localparam int DIV  = 12;
  localparam int CNV  = 4;
  localparam int TMO  = 64;
  localparam int NRUN = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trig = 1'b0;
  logic clr = 1'b0;
  logic busy = 1'b0;
  logic sdo = 1'b0;
  logic cnv_w, sclk_w, valid_w, ovr_w, tmo_w;
  logic [W-1:0] word_w;

  always #2 clk = ~clk; // 250 MHz

  adc_burst_ctrl #(.WORD_W(W), .SCLK_DIV(DIV), .CNV_CYCLES(CNV), .TIMEOUT(TMO)) u0 (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .clr_i(clr), .busy_i(busy), .sdo_i(sdo),
    .cnv_o(cnv_w), .sclk_o(sclk_w), .word_valid_o(valid_w), .word_o(word_w),
    .overrun_o(ovr_w), .timeout_o(tmo_w)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done_flag = 1'b0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  function automatic logic [W-1:0] exp_word(input int n);
    logic [19:0] body;
    body = 20'((n * 40503 + 777) & 32'hFFFFF);
    return {n[3:0], body};
  endfunction

  // converter model: 0 normal, 1 never busy, 2 busy stuck high
  int mdl_mode = 0;
  int mdl_idx  = 0;
  int bit_left = 0;
  logic [W-1:0] cur_word = '0;

  always begin
    @(posedge cnv_w);
    if (mdl_mode == 0) begin
      repeat (2) @(negedge clk);
      busy = 1'b1;
      repeat (2 + (mdl_idx * 7) % 11) @(negedge clk);
      cur_word = exp_word(mdl_idx);
      bit_left = W - 1;
      sdo      = cur_word[W-1];
      mdl_idx++;
      busy     = 1'b0;
    end else if (mdl_mode == 2) begin
      @(negedge clk);
      busy = 1'b1;
    end
  end

  always @(negedge sclk_w) begin
    if (bit_left > 0) begin
      bit_left--;
      sdo = cur_word[bit_left];
    end
  end

  // monitor, sampled on the falling system clock edge
  int  cyc = 0;
  int  words_seen = 0;
  int  cnv_run = 0;
  int  cnv_pulses = 0;
  int  rises = 0;
  int  last_rise = 0;
  int  hi_cnt = 0;
  int  stray = 0;
  logic sclk_prev = 1'b0;
  logic valid_prev = 1'b0;
  logic cnv_prev = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (sclk_w && !(mdl_idx > words_seen)) stray++;     // R2 / R4
      if (cnv_w) cnv_run++;
      if (!cnv_w && cnv_prev) begin
        check(cnv_run == CNV, "R1 convert width", cnv_run, CNV);
        cnv_pulses++;
        cnv_run = 0;
      end
      if (sclk_w) hi_cnt++;
      if (sclk_w && !sclk_prev) begin
        if (rises > 0) check(cyc - last_rise == DIV, "R5 period", cyc - last_rise, DIV);
        rises++;
        last_rise = cyc;
      end
      if (!sclk_w && sclk_prev) begin
        check(hi_cnt == DIV - DIV / 2, "R5 high width", hi_cnt, DIV - DIV / 2);
        hi_cnt = 0;
      end
      if (valid_w) begin
        check(!valid_prev, "R6 strobe single cycle", valid_prev, 0);
        check(word_w == exp_word(words_seen), "R6/R7 word order", word_w, exp_word(words_seen));
        check(rises == W, "R3 edges per burst", rises, W);
        rises = 0;
        words_seen++;
      end
    end
    sclk_prev  = sclk_w;
    valid_prev = valid_w;
    cnv_prev   = cnv_w;
  end

  task automatic pulse_trig();
    @(negedge clk) trig = 1'b1;
    @(negedge clk) trig = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
  endtask

  task automatic run_conv(input int gap);
    int start;
    start = words_seen;
    pulse_trig();
    for (int k = 0; k < 2000 && words_seen == start; k++) @(negedge clk);
    check(words_seen == start + 1, "R7 word delivered", words_seen, start + 1);
    repeat (gap) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", cyc, 0);
    finish_run();
  end

  initial begin
    int p0, w0;
    repeat (3) @(negedge clk);
    check({cnv_w, sclk_w, valid_w, ovr_w, tmo_w} == 5'b0, "R10 reset outputs",
          {cnv_w, sclk_w, valid_w, ovr_w, tmo_w}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check({cnv_w, sclk_w, valid_w, ovr_w, tmo_w} == 5'b0, "R10 after release",
          {cnv_w, sclk_w, valid_w, ovr_w, tmo_w}, 0);

    // R7: long run, wraps the channel nibble twice
    for (int i = 0; i < NRUN; i++) run_conv(i % 4);
    check(words_seen == NRUN, "R7 total words", words_seen, NRUN);
    check(cnv_pulses == NRUN, "R1 one pulse per trigger", cnv_pulses, NRUN);
    check(ovr_w == 1'b0 && tmo_w == 1'b0, "R8/R9 flags quiet", {ovr_w, tmo_w}, 0);

    // R8: trigger during conversion
    p0 = cnv_pulses;
    w0 = words_seen;
    pulse_trig();
    repeat (3) @(negedge clk);
    pulse_trig();
    for (int k = 0; k < 2000 && words_seen == w0; k++) @(negedge clk);
    repeat (30) @(negedge clk);
    check(ovr_w == 1'b1, "R8 overrun set", ovr_w, 1);
    check(cnv_pulses == p0 + 1, "R8 no extra convert", cnv_pulses, p0 + 1);
    check(words_seen == w0 + 1, "R8 single word", words_seen, w0 + 1);
    repeat (5) @(negedge clk);
    check(ovr_w == 1'b1, "R8 overrun sticky", ovr_w, 1);
    pulse_clr();
    @(negedge clk);
    check(ovr_w == 1'b0, "R8 overrun cleared", ovr_w, 0);

    // R9: converter never raises busy
    mdl_mode = 1;
    w0 = words_seen;
    pulse_trig();
    repeat (TMO + CNV + 20) @(negedge clk);
    check(tmo_w == 1'b1, "R9 timeout set (no busy)", tmo_w, 1);
    check(words_seen == w0, "R9 no word", words_seen, w0);
    pulse_clr();
    @(negedge clk);
    check(tmo_w == 1'b0, "R9 timeout cleared", tmo_w, 0);

    // R9 / R2: busy stuck high, then falls while idle
    mdl_mode = 2;
    pulse_trig();
    repeat (TMO + CNV + 20) @(negedge clk);
    check(tmo_w == 1'b1, "R9 timeout set (busy stuck)", tmo_w, 1);
    @(negedge clk) busy = 1'b0;
    repeat (3 * DIV) @(negedge clk);
    check(words_seen == w0, "R2 idle fall gives no word", words_seen, w0);
    pulse_clr();

    // R9: normal operation resumes
    mdl_mode = 0;
    run_conv(2);
    run_conv(0);
    check(tmo_w == 1'b0, "R9 stays clear", tmo_w, 0);
    check(stray == 0, "R2/R4 clock gated outside window", stray, 0);
    finish_run();
  end

endmodule